// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the serial slave output stage of a sampling converter. It holds a 16-bit result in a shift register and moves it onto a single data line, most significant bit first. Each falling edge of a host-driven serial clock advances it by one bit. A conversion-start strobe begins a timed conversion, which a busy flag marks. When busy falls, the new result from the conversion timer is loaded for reading.

The block has two read modes, chosen by a mode input. In the after-conversion mode, the host reads only while the block is idle. A cascade input captures an upstream device's bits and lets them follow the local word on the same line, so several devices can share one data wire. In the overlapped mode, the host reads the previous result while the next conversion runs. The cascade input is ignored in this mode. If a word has been started but not finished when the conversion ends, a one-cycle read-error strobe is raised. The serial clock is oversampled by the system clock, and its edges are detected from a registered copy.

Top module: `ser_readout`

## Requirements
- R1: While reset is asserted, and immediately after it, `sdout`, `busy` and `rd_err` are low.
- R2: A `cnv_start` sampled while `busy` is low raises `busy` on the next clock, and `busy` then stays high for exactly CONV_CYCLES clocks. A `cnv_start` sampled while `busy` is high has no effect.
- R3: In the clock where `busy` falls, `result_in` is loaded into the shift register, and its bit 15 appears on `sdout`.
- R4: While `cs_n` and `rd_n` are both low, each falling edge of `sclk` advances the word by one bit, MSB first. `sdout` changes only after a falling `sclk` edge or a load, so it is stable across each rising edge. Sixteen pulses deliver the whole word.
- R5: With `mode_overlap` = 0, `sclk` edges that occur while `busy` is high do not move `sdout`.
- R6: With `mode_overlap` = 0, `chain_in` is captured on the rising `sclk` edge. The captured bits enter behind the local word, so the upstream MSB appears on `sdout` right after the 16th falling edge, and 32 pulses deliver {local word, upstream word}.
- R7: With `mode_overlap` = 1, the host may read while `busy` is high, and the word it receives is the result of the previous conversion.
- R8: With `mode_overlap` = 1, `chain_in` is ignored and zeros follow the local word.
- R9: With `mode_overlap` = 1, if between 1 and 15 bits of the current word have been shifted when `busy` falls, `rd_err` is high for exactly one clock, the same clock in which `busy` is first low.
- R10: `rd_err` stays low when the word was fully read, when no bit was read, and always in `mode_overlap` = 0.
- R11: `cs_n` high clears the count of bits read, so a word abandoned by deselecting raises no read error.
- R12: With `mode_overlap` = 1, a read begun after one conversion may finish while the next conversion is busy, and it delivers the complete earlier word without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_start | input | 1 | Conversion start strobe |
| mode_overlap | input | 1 | 0: read after conversion with cascade; 1: read during conversion |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk | input | 1 | Host serial clock, oversampled |
| chain_in | input | 1 | Cascade data from upstream device |
| result_in | input | 16 | Result word from the conversion timer |
| sdout | output | 1 | Serial data out |
| busy | output | 1 | Conversion in progress |
| rd_err | output | 1 | One-clock strobe for an unfinished read |

## Verification
A start strobe driven before a clock edge shows as `busy` after that edge, and the bench counts the half-period samples in which `busy` is high to check the CONV_CYCLES length. Serial edges take one clock to detect, so after changing `sclk` the bench waits two clocks before it samples `sdout` or changes the clock again. The bench reads each bit just before raising `sclk`, the point where the bit is guaranteed settled. The read-error strobe is counted at every falling system-clock edge, which catches a missing pulse, an extra pulse and a pulse that lasts two cycles.

// File: rtl/ser_readout.sv
module ser_readout #(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_start,
  input  logic             mode_overlap,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sclk,
  input  logic             chain_in,
  input  logic [WIDTH-1:0] result_in,
  output logic             sdout,
  output logic             busy,
  output logic             rd_err
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int BW = $clog2(WIDTH + 1);

  logic             sclk_q;
  logic             chain_q;
  logic [CW-1:0]    conv_cnt;
  logic [WIDTH-1:0] shreg;
  logic [BW-1:0]    bits;

  logic sclk_rise, sclk_fall, may_shift, conv_done, partial;
  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign may_shift = ~cs_n & ~rd_n & (mode_overlap | ~busy);
  assign conv_done = busy && (conv_cnt == '0);
  assign partial   = (bits != '0) && (bits < BW'(WIDTH));
  assign sdout     = shreg[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      chain_q  <= 1'b0;
      busy     <= 1'b0;
      conv_cnt <= '0;
      shreg    <= '0;
      bits     <= '0;
      rd_err   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      rd_err <= 1'b0;
      if (sclk_rise) chain_q <= chain_in;

      if (busy) begin
        if (conv_cnt == '0) busy <= 1'b0;
        else                conv_cnt <= conv_cnt - 1'b1;
      end else if (cnv_start) begin
        busy     <= 1'b1;
        conv_cnt <= CW'(CONV_CYCLES - 1);
      end

      if (conv_done) begin
        shreg  <= result_in;
        bits   <= '0;
        rd_err <= mode_overlap & partial;
      end else if (cs_n) begin
        bits <= '0;
      end else if (may_shift && sclk_fall) begin
        shreg <= {shreg[WIDTH-2:0], chain_q & ~mode_overlap};
        if (bits != BW'(WIDTH)) bits <= bits + 1'b1;
      end
    end
  end
endmodule

module ser_readout_chk (
  input logic clk,
  input logic rst_n,
  input logic cnv_start,
  input logic mode_overlap,
  input logic sclk,
  input logic sdout,
  input logic busy,
  input logic rd_err
);
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnv_start) |=> busy); // R2
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err); // R9
  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> ($fell(busy) && $past(mode_overlap))); // R10
  AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> (($past(sclk, 2) && !$past(sclk)) || $fell(busy))); // R4
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(mode_overlap)) |-> $stable(sdout)); // R5
endmodule

bind ser_readout ser_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .mode_overlap(mode_overlap),
  .sclk(sclk), .sdout(sdout), .busy(busy), .rd_err(rd_err));

// File: tb/test_ser_readout.sv
module test_ser_readout;
  localparam int CONV = 100;
  localparam int NV   = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'hA5C3_3C5A, 32'hFFFF_0000, 32'h0000_FFFF,
    32'h8001_7FFE, 32'h1234_FEDC, 32'h0F0F_F0F0};

  logic clk = 1'b0, rst_n = 1'b0, cnv_start = 1'b0, mode_overlap = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, sclk = 1'b0, chain_in = 1'b0;
  logic [15:0] result_in = '0;
  logic sdout, busy, rd_err;

  int n_chk = 0, n_fail = 0, err_pulses = 0, err_wide = 0, blen = 0;
  logic err_prev = 1'b0;
  logic [31:0] got;
  bit done = 0;

  ser_readout #(.WIDTH(16), .CONV_CYCLES(CONV)) i_ser_readout (
    .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .mode_overlap(mode_overlap),
    .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .chain_in(chain_in),
    .result_in(result_in), .sdout(sdout), .busy(busy), .rd_err(rd_err));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rd_err) err_pulses++;
    if (rd_err && err_prev) err_wide++;
    err_prev = rd_err;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_conv(input logic [15:0] val);
    result_in = val; cnv_start = 1'b1; tick(1); cnv_start = 1'b0;
  endtask

  task automatic wait_done();
    blen = 0;
    while (busy) begin blen++; tick(1); end
  endtask

  task automatic read_bits(input int n, input logic [31:0] up);
    logic [31:0] u = up;
    for (int k = 0; k < n; k++) begin
      got = {got[30:0], sdout};
      chain_in = u[31]; u = {u[30:0], 1'b0};
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(2);
    end
  endtask

  task automatic deselect();
    cs_n = 1'b1; rd_n = 1'b1; tick(1); cs_n = 1'b0; rd_n = 1'b0;
  endtask

  initial begin
    int e0;
    tick(3);
    check("R1 sdout", 32'(sdout), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 rd_err", 32'(rd_err), 0);
    rst_n = 1'b1; tick(1);
    check("R1 after release", {29'd0, sdout, busy, rd_err}, 0);

    for (int v = 0; v < NV; v++) begin
      mode_overlap = 1'b0; deselect();
      start_conv(VEC[v][31:16]); wait_done();
      check("R2 busy length", blen, CONV);
      check("R3 MSB after load", 32'(sdout), 32'(VEC[v][31]));
      got = '0; read_bits(32, {VEC[v][15:0], 16'h0});
      check("R4 R6 cascade word", got, VEC[v]);
    end

    deselect();
    start_conv(16'h1111); tick(10);
    cnv_start = 1'b1; tick(1); cnv_start = 1'b0;
    wait_done();
    check("R2 start ignored while busy", blen + 11, CONV);
    tick(3);
    check("R2 no second conversion", 32'(busy), 0);

    deselect(); e0 = err_pulses;
    start_conv(16'hA5C3); wait_done();
    got = '0; read_bits(5, 0);
    start_conv(16'h5A5A);
    read_bits(4, 0);
    check("R5 sdout held while busy", 32'(sdout), 32'(1'b1));
    wait_done();
    check("R10 no error in mode 0", err_pulses - e0, 0);
    got = '0; read_bits(16, 0);
    check("R5 next word intact", got, 32'h5A5A);

    mode_overlap = 1'b1; deselect(); e0 = err_pulses;
    start_conv(16'hC3A5); wait_done();
    start_conv(16'h6B2D);
    got = '0; read_bits(16, 0);
    check("R7 previous word during conversion", got, 32'hC3A5);
    check("R7 still busy", 32'(busy), 1);
    wait_done();
    check("R10 full read no error", err_pulses - e0, 0);
    check("R3 new word MSB", 32'(sdout), 0);

    deselect(); e0 = err_pulses;
    start_conv(16'h9999);
    got = '0; read_bits(5, 0);
    wait_done(); tick(2);
    check("R9 partial read error pulse", err_pulses - e0, 1);
    check("R9 pulse one clock", err_wide, 0);

    deselect(); e0 = err_pulses;
    start_conv(16'h7777);
    read_bits(5, 0);
    cs_n = 1'b1; tick(1); cs_n = 1'b0;
    wait_done(); tick(2);
    check("R11 deselect clears count", err_pulses - e0, 0);
    e0 = err_pulses;
    start_conv(16'h3333); wait_done(); tick(2);
    check("R10 no read no error", err_pulses - e0, 0);

    deselect(); e0 = err_pulses;
    got = '0; read_bits(8, 0);
    start_conv(16'hBEEF);
    read_bits(8, 0);
    check("R12 split read word", got[15:0], 32'h3333);
    wait_done(); tick(2);
    check("R12 no error", err_pulses - e0, 0);

    deselect();
    got = '0; read_bits(24, 32'hFFFF_FFFF);
    check("R8 cascade ignored", got[23:0], 32'hBEEF00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule